// File: doc/BRIEF.md
# Cell Bus Clock and Frame-Sync Monitor

This block watches three slow lines of a shared cell bus, the write clock, the read clock and the frame-sync strobe, from a free-running master clock. Each line passes through a two-flop synchronizer into the master domain. A clock counts as alive while edges keep arriving. The frame-sync strobe counts as alive while it shows up often enough, measured in rising read-clock edges.

When a line dies, a sticky fault flag latches in a three-bit status vector. Software clears a flag by writing a one to its bit. A single interrupt line is the OR of the flags that have their enable bits set. The allowed frame-sync interval depends on the bus population: 16 read-clock rising edges in the small configuration and 32 in the large one. The frame-sync flag is also raised whenever the write clock is lost, because frame sync is launched by that clock.

Top module: `cbus_clk_monitor`

## Requirements
- R1: `status[0]` (write clock lost) sets after `wrClkIn` has shown no edge for 32 consecutive master-clock cycles, as seen through the synchronizer. Either edge counts as activity.
- R2: `status[1]` (read clock lost) sets after `rdClkIn` has shown no edge for 32 consecutive master-clock cycles, as seen through the synchronizer.
- R3: With `mode32` = 0, `status[2]` (frame sync lost) sets when 16 rising edges of the read clock are seen while `fsyncIn` is seen low. Seeing `fsyncIn` high restarts the count.
- R4: With `mode32` = 1, the frame-sync interval limit is 32 rising read-clock edges instead of 16.
- R5: The event that sets `status[0]` also sets `status[2]` in the same cycle.
- R6: All flags are 0 after reset. A set flag stays set until it is cleared.
- R7: `irq` is high exactly when some bit of `status & enBits` is 1.
- R8: A 1 on `clrBits[i]` clears `status[i]` at the next master clock edge. If a fault for bit i is detected in that same cycle, the flag is set instead of cleared.
- R9: Each loss is reported once. The inactivity and interval counters saturate at their limits. A flag that is cleared while its line is still dead stays clear until the line recovers and is lost again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrClkIn | input | 1 | Cell bus write clock (asynchronous) |
| rdClkIn | input | 1 | Cell bus read clock (asynchronous) |
| fsyncIn | input | 1 | Cell bus frame-sync strobe (asynchronous) |
| mode32 | input | 1 | 1 = 32-user interval limit, 0 = 16-user |
| clrBits | input | 3 | Write-one-to-clear strobes, one per flag |
| enBits | input | 3 | Interrupt enables, one per flag |
| status | output | 3 | Latched flags: [0] write clock, [1] read clock, [2] frame sync |
| irq | output | 1 | Interrupt request |

## Verification
A level on any monitored line is first seen by the counters three master edges after it is sampled. The write-clock and read-clock flags therefore appear 32 edges after the last edge seen there. The frame-sync flag appears on the master edge that follows the sixteenth or thirty-second seen read-clock rise. A clear takes effect one edge after it is driven. `irq` follows the flags and the enables combinationally. The bench reference model keeps a three-sample history of each line and updates its own counters on every master edge. It compares all flags and `irq` at the falling edge, when all of these results have settled. Directed checks after each stimulus phase wait well past these latencies before they sample.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_WR   = 0;
  localparam int unsigned FLAG_RD   = 1;
  localparam int unsigned FLAG_FS   = 2;

  // one-cycle fault detections passed from datapath to control
  typedef struct packed {
    logic fsLost;
    logic rdLost;
    logic wrLost;
  } faultStrobes_t;
endpackage

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_LIMIT  = 32,
  parameter int unsigned FS_LIMIT_LO = 16,
  parameter int unsigned FS_LIMIT_HI = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrClkIn,
  input  logic          rdClkIn,
  input  logic          fsyncIn,
  input  logic          mode32,
  output faultStrobes_t strobes
);
  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned NUM_CLKS  = 2;
  localparam int unsigned IDLE_W    = $clog2(IDLE_LIMIT + 1);
  localparam int unsigned FS_MAX    = (FS_LIMIT_HI > FS_LIMIT_LO) ? FS_LIMIT_HI : FS_LIMIT_LO;
  localparam int unsigned FS_W      = $clog2(FS_MAX + 1);

  logic [NUM_LINES-1:0] lineIn;
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] prevSynced;
  logic [NUM_CLKS-1:0]  quietHit;

  assign lineIn = {fsyncIn, rdClkIn, wrClkIn};

  // synchronizer chain plus one history flop per monitored line
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[SYNC_STAGES-1:0], lineIn[i]};
    end
    assign synced[i]     = pipe[SYNC_STAGES-1];
    assign prevSynced[i] = pipe[SYNC_STAGES];
  end

  // inactivity counters for the two clocks, saturating at the limit
  for (genvar c = 0; c < NUM_CLKS; c++) begin : g_idle
    logic [IDLE_W-1:0] idleCnt;
    logic              seenEdge;
    assign seenEdge = synced[c] ^ prevSynced[c];
    always_ff @(posedge clk) begin
      if (!rst_n)                             idleCnt <= '0;
      else if (seenEdge)                      idleCnt <= '0;
      else if (idleCnt != IDLE_W'(IDLE_LIMIT)) idleCnt <= idleCnt + 1'b1;
    end
    assign quietHit[c] = !seenEdge && (idleCnt == IDLE_W'(IDLE_LIMIT - 1));
  end

  // frame-sync interval counter, clocked by seen read-clock rises
  logic [FS_W-1:0] fsCnt;
  logic [FS_W-1:0] fsLimit;
  logic            rdRise;
  logic            fsHigh;

  assign fsLimit = mode32 ? FS_W'(FS_LIMIT_HI) : FS_W'(FS_LIMIT_LO);
  assign rdRise  = synced[FLAG_RD] & ~prevSynced[FLAG_RD];
  assign fsHigh  = synced[FLAG_FS];

  always_ff @(posedge clk) begin
    if (!rst_n)                         fsCnt <= '0;
    else if (fsHigh)                    fsCnt <= '0;
    else if (rdRise && fsCnt < fsLimit) fsCnt <= fsCnt + 1'b1;
  end

  assign strobes.wrLost = quietHit[FLAG_WR];
  assign strobes.rdLost = quietHit[FLAG_RD];
  assign strobes.fsLost = !fsHigh && rdRise && (fsCnt == fsLimit - 1'b1);
endmodule

// File: rtl/cbm_control.sv
module cbm_control
  import cbm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  faultStrobes_t        strobes,
  input  logic [NUM_FLAGS-1:0] clrBits,
  input  logic [NUM_FLAGS-1:0] enBits,
  output logic [NUM_FLAGS-1:0] status,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] flags;

  // a lost write clock also means frame sync is gone
  assign setVec[FLAG_WR] = strobes.wrLost;
  assign setVec[FLAG_RD] = strobes.rdLost;
  assign setVec[FLAG_FS] = strobes.fsLost | strobes.wrLost;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clrBits) | setVec;
  end

  assign status = flags;
  assign irq    = |(flags & enBits);
endmodule

// File: rtl/cbus_clk_monitor.sv
module cbus_clk_monitor
  import cbm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_LIMIT  = 32,
  parameter int unsigned FS_LIMIT_LO = 16,
  parameter int unsigned FS_LIMIT_HI = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrClkIn,
  input  logic       rdClkIn,
  input  logic       fsyncIn,
  input  logic       mode32,
  input  logic [2:0] clrBits,
  input  logic [2:0] enBits,
  output logic [2:0] status,
  output logic       irq
);
  faultStrobes_t strobes;

  cbm_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_LIMIT (IDLE_LIMIT),
    .FS_LIMIT_LO(FS_LIMIT_LO),
    .FS_LIMIT_HI(FS_LIMIT_HI)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrClkIn(wrClkIn),
    .rdClkIn(rdClkIn),
    .fsyncIn(fsyncIn),
    .mode32 (mode32),
    .strobes(strobes)
  );

  cbm_control u_control (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .clrBits(clrBits),
    .enBits (enBits),
    .status (status),
    .irq    (irq)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int unsigned IDLE_LIMIT = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wrClkIn,
  input logic       rdClkIn,
  input logic [2:0] clrBits,
  input logic [2:0] enBits,
  input logic [2:0] status,
  input logic       irq
);
  logic [15:0] wrQuiet, rdQuiet;
  logic        wrPrev, rdPrev;

  // cycles since each clock pin last changed, counted at the pins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrQuiet <= '0; rdQuiet <= '0; wrPrev <= 1'b0; rdPrev <= 1'b0;
    end else begin
      wrPrev  <= wrClkIn;
      rdPrev  <= rdClkIn;
      wrQuiet <= (wrClkIn != wrPrev) ? 16'd0 : ((wrQuiet == 16'hFFFF) ? wrQuiet : wrQuiet + 16'd1);
      rdQuiet <= (rdClkIn != rdPrev) ? 16'd0 : ((rdQuiet == 16'hFFFF) ? rdQuiet : rdQuiet + 16'd1);
    end
  end

  p_wr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (wrQuiet >= 16'(IDLE_LIMIT - 1)));

  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> (rdQuiet >= 16'(IDLE_LIMIT - 1)));

  p_fs_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> status[2]);

  p_reset_clear_r6: assert property (@(posedge clk)
    !rst_n |=> (status == 3'b000));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~clrBits) != 3'b000) |=> (((($past(status) & ~$past(clrBits))) & ~status) == 3'b000));

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enBits) == 3'b000) |-> !irq);

  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enBits) != 3'b000) |-> irq);
endmodule

bind cbus_clk_monitor cbm_checker #(.IDLE_LIMIT(IDLE_LIMIT)) u_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .wrClkIn(wrClkIn),
  .rdClkIn(rdClkIn),
  .clrBits(clrBits),
  .enBits (enBits),
  .status (status),
  .irq    (irq)
);

// File: tb/cbus_clk_monitor_tb.sv
module cbus_clk_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrClk = 1'b0, rdClk = 1'b0, fsync = 1'b0;
  logic       mode32 = 1'b0;
  logic [2:0] clr = 3'b000, en = 3'b000;
  logic [2:0] status;
  logic       irq;

  always #5 clk = ~clk;

  cbus_clk_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .wrClkIn(wrClk), .rdClkIn(rdClk), .fsyncIn(fsync),
    .mode32(mode32), .clrBits(clr), .enBits(en), .status(status), .irq(irq)
  );

  int  checks = 0, fails = 0, cyc = 0;
  bit  done = 0;

  // ---------------- stimulus clocks ----------------
  bit wrRun = 1, rdRun = 1, fsOn = 1;
  int wrHalf = 3, rdHalf = 2, fsEvery = 8;
  int wrPh = 0, rdPh = 0, rdEdges = 0;

  always @(posedge clk) begin
    #1;
    if (wrRun) begin
      wrPh++;
      if (wrPh >= wrHalf) begin wrPh = 0; wrClk = ~wrClk; end
    end
    if (rdRun) begin
      rdPh++;
      if (rdPh >= rdHalf) begin
        rdPh = 0; rdClk = ~rdClk;
        if (rdClk) begin
          rdEdges++;
          fsync = fsOn && (rdEdges % fsEvery == 0);
        end
      end
    end
  end

  // ---------------- behavioural reference ----------------
  bit wH[3], rH[3], fH[3];
  int mWrIdle = 0, mRdIdle = 0, mFsCnt = 0;
  bit [2:0] mFlags = 3'b000;

  always @(posedge clk) begin
    bit newW, newR, newF;
    int lim;
    if (!rst_n) begin
      foreach (wH[k]) begin wH[k] = 0; rH[k] = 0; fH[k] = 0; end
      mWrIdle = 0; mRdIdle = 0; mFsCnt = 0; mFlags = 3'b000;
    end else begin
      newW = 0; newR = 0; newF = 0;
      if (wH[1] != wH[2]) mWrIdle = 0;
      else if (mWrIdle < 32) begin mWrIdle++; newW = (mWrIdle == 32); end
      if (rH[1] != rH[2]) mRdIdle = 0;
      else if (mRdIdle < 32) begin mRdIdle++; newR = (mRdIdle == 32); end
      lim = mode32 ? 32 : 16;
      if (fH[1]) mFsCnt = 0;
      else if (rH[1] && !rH[2] && mFsCnt < lim) begin mFsCnt++; newF = (mFsCnt == lim); end
      mFlags = (mFlags & ~clr) | {newF | newW, newR, newW};
      wH[2] = wH[1]; wH[1] = wH[0]; wH[0] = wrClk;
      rH[2] = rH[1]; rH[1] = rH[0]; rH[0] = rdClk;
      fH[2] = fH[1]; fH[1] = fH[0]; fH[0] = fsync;
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (status[0] !== mFlags[0]) begin fails++; $display("FAIL R1 write-clock flag: got %0b expected %0b at cycle %0d", status[0], mFlags[0], cyc); end
      if (status[1] !== mFlags[1]) begin fails++; $display("FAIL R2 read-clock flag: got %0b expected %0b at cycle %0d", status[1], mFlags[1], cyc); end
      if (status[2] !== mFlags[2]) begin fails++; $display("FAIL R3 frame-sync flag: got %0b expected %0b at cycle %0d", status[2], mFlags[2], cyc); end
      if (irq !== |(mFlags & en)) begin fails++; $display("FAIL R7 irq: got %0b expected %0b at cycle %0d", irq, |(mFlags & en), cyc); end
    end
  end

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear(input logic [2:0] bits);
    @(posedge clk); #1; clr = bits;
    @(posedge clk); #1; clr = 3'b000;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      finish_run();
    end
  end

  initial begin
    bit sawHigh;
    wait_cycles(5);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bit("R6 reset status", |status, 1'b0);
    expect_bit("R7 reset irq", irq, 1'b0);

    // healthy bus, 16-user mode, frame sync every 8 read edges
    wait_cycles(400);
    expect_bit("R3 no false frame-sync alarm", status[2], 1'b0);
    expect_bit("R1 no false write alarm", status[0], 1'b0);

    // frame sync stops -> flag after 16 read rises
    fsOn = 0;
    wait_cycles(200);
    expect_bit("R3 frame-sync lost in 16-user mode", status[2], 1'b1);
    wait_cycles(20);
    expect_bit("R6 flag stays set", status[2], 1'b1);

    // clear while still lost: no second report
    pulse_clear(3'b100);
    wait_cycles(100);
    expect_bit("R8/R9 cleared flag stays clear while saturated", status[2], 1'b0);

    // 24-edge interval is fine in 32-user mode
    mode32 = 1; fsEvery = 24; fsOn = 1;
    wait_cycles(500);
    expect_bit("R4 24-edge interval accepted in 32-user mode", status[2], 1'b0);

    // same interval fails in 16-user mode
    mode32 = 0;
    wait_cycles(300);
    expect_bit("R3 24-edge interval rejected in 16-user mode", status[2], 1'b1);
    fsEvery = 8;
    wait_cycles(60);
    pulse_clear(3'b100);
    wait_cycles(100);
    expect_bit("R8 clear after recovery", status[2], 1'b0);

    // read clock stops
    rdRun = 0;
    wait_cycles(60);
    expect_bit("R2 read clock lost", status[1], 1'b1);
    expect_bit("R3 no frame-sync flag without read rises", status[2], 1'b0);
    rdRun = 1;
    wait_cycles(40);
    pulse_clear(3'b010);
    wait_cycles(40);
    expect_bit("R8 read flag cleared", status[1], 1'b0);

    // write clock stops, only read enable set
    en = 3'b010;
    wrRun = 0;
    wait_cycles(60);
    expect_bit("R1 write clock lost", status[0], 1'b1);
    expect_bit("R5 frame-sync forced by write loss", status[2], 1'b1);
    expect_bit("R7 irq masked", irq, 1'b0);
    en = 3'b001;
    #1;
    expect_bit("R7 irq enabled", irq, 1'b1);

    pulse_clear(3'b101);
    wait_cycles(80);
    expect_bit("R9 write flag stays clear while clock still dead", status[0], 1'b0);

    // restart, then stop again with clear held: set must win once
    wrRun = 1;
    wait_cycles(30);
    clr = 3'b001;
    wrRun = 0;
    sawHigh = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (status[0]) sawHigh = 1;
    end
    expect_bit("R8 set wins over simultaneous clear", sawHigh, 1'b1);
    expect_bit("R8 held clear removes flag afterwards", status[0], 1'b0);
    clr = 3'b000;
    wrRun = 1;
    wait_cycles(50);
    pulse_clear(3'b111);
    wait_cycles(20);
    expect_bit("R6 all clear at end", |status, 1'b0);

    finish_run();
  end
endmodule